// File: doc/BRIEF.md
# Nine-bit multiprocessor serial link

This block is a serial receiver and transmitter pair for a shared master/slave bus that uses eleven-bit frames. Each frame holds a low start bit, eight data bits sent least significant bit first, a ninth bit and a high stop bit. A ninth bit of 1 marks the frame as an address, and a ninth bit of 0 marks it as data. A master opens a message with one address frame and follows it with data frames.

On a slave, the address-filter input lets software ignore traffic that is not meant for it. While the input is set, only address frames with a good stop bit reach the received byte and raise the receive interrupt. When software recognises its own address, it clears the input so that the data frames that follow are delivered. It sets the input again once the message has ended. The received ninth bit is latched into a status output on every frame, including frames that are filtered out.

The bit rate comes from an internal 8-bit timer that reloads itself and gives one oversampling tick every 256 − reload clocks. Each bit lasts 16 ticks. The receiver votes on three samples around the middle of each bit and rejects a start bit that is no longer low at mid-bit.

Top module: `nbl_top`

## Requirements
- R1: The transmitter sends the frame as: start 0, then `tx_byte_i` bits 0..7 in that order, then `tx_bit9_i`, then stop 1. Each bit holds for exactly 16·(256 − `reload_i`) clocks. The line idles high.
- R2: `tx_done_o` is a one-clock pulse at the end of the stop bit. A `tx_start_i` strobe that arrives while a frame is pending or being sent has no effect.
- R3: With `addr_filt_i` = 0, every received frame raises a one-clock `rx_irq_o` pulse and loads its data byte into `rx_byte_o`, whatever its ninth bit is.
- R4: With `addr_filt_i` = 1, a received frame with ninth bit 1 and a high stop bit raises `rx_irq_o` and loads `rx_byte_o`.
- R5: With `addr_filt_i` = 1, a frame with ninth bit 0 raises no `rx_irq_o` and leaves `rx_byte_o` unchanged.
- R6: With `addr_filt_i` = 1, a frame with ninth bit 1 whose stop bit samples low raises no `rx_irq_o` and leaves `rx_byte_o` unchanged.
- R7: A low pulse on `rx_i` that is shorter than half a bit time is rejected as a false start. It produces no interrupt and no change of `rx_byte_o`.
- R8: The oversampling tick has a period of 256 − `reload_i` clocks, so the divide from clock to bit rate is 16·(256 − `reload_i`).
- R9: `rx_bit9_o` takes the received ninth bit at the middle of every stop bit, including frames that R5 or R6 filter out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line |
| reload_i | input | 8 | Reload value of the bit-rate timer |
| addr_filt_i | input | 1 | 1: only address frames are delivered |
| tx_byte_i | input | 8 | Byte to transmit |
| tx_bit9_i | input | 1 | Ninth bit to transmit (1 = address) |
| tx_start_i | input | 1 | One-clock strobe that starts a transmission |
| tx_o | output | 1 | Serial transmit line |
| rx_byte_o | output | 8 | Last delivered received byte |
| rx_bit9_o | output | 1 | Ninth bit of the last received frame |
| rx_irq_o | output | 1 | One-clock pulse: a frame was delivered |
| tx_done_o | output | 1 | One-clock pulse: the stop bit has been sent |

## Verification
The receive decision at mid-stop and the end of a transmitted stop bit both fire on a tick edge, so `rx_irq_o` and `tx_done_o` can pulse in the same clock. The bench provokes this by starting a transmission and then launching a received frame at a delay that it sweeps tick by tick over a full bit time, which makes some offsets line up both pulses. For every offset it checks that each pulse appears exactly once and that the received byte is correct. It also reports how many of the offsets produced a coincidence.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;
endpackage

// File: rtl/nbl_baud.sv
module nbl_baud #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] reload_i,
  output logic             tick_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             tick_q, wrap;

  always_comb begin
    wrap  = (cnt_q == '1);
    cnt_d = wrap ? reload_i : cnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= wrap;
    end
  end

  assign tick_o = tick_q;

  // R8
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && cnt_q != '1) |=> !tick_q);
endmodule

// File: rtl/nbl_rx.sv
module nbl_rx
  import nbl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              filt_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              bit9_o,
  output logic              irq_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 1);
  localparam int SW = DATA_W + 1;
  localparam logic [CW-1:0] S_PRE  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] S_MID  = CW'(OVS/2);
  localparam logic [CW-1:0] S_DEC  = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] S_LAST = CW'(OVS - 1);

  rx_state_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [SW-1:0]     sh_q, sh_d;
  logic [1:0]        smp_q, smp_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              b9_q, b9_d, irq_q, irq_d;
  logic [1:0]        sync_q;
  logic              rx_s, vote, accept;

  assign rx_s = sync_q[1];
  assign vote = (smp_q[1] & smp_q[0]) | (smp_q[1] & rx_s) | (smp_q[0] & rx_s);
  assign accept = !filt_i || (sh_q[DATA_W] && vote);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q; sh_d = sh_q; smp_d = smp_q;
    byte_d = byte_q; b9_d = b9_q; irq_d = 1'b0;
    if (tick_i) begin
      cnt_d = (cnt_q == S_LAST) ? '0 : cnt_q + CW'(1);
      if (cnt_q == S_PRE || cnt_q == S_MID) smp_d = {smp_q[0], rx_s};
      unique case (st_q)
        RX_IDLE: begin
          cnt_d = '0;
          if (!rx_s) begin
            st_d  = RX_START;
            cnt_d = CW'(1);
          end
        end
        RX_START: begin
          if (cnt_q == S_DEC && vote) begin
            st_d  = RX_IDLE;
            cnt_d = '0;
          end else if (cnt_q == S_LAST) begin
            st_d  = RX_DATA;
            bit_d = '0;
          end
        end
        RX_DATA: begin
          if (cnt_q == S_DEC) sh_d = {vote, sh_q[SW-1:1]};
          if (cnt_q == S_LAST) begin
            if (bit_q == BW'(DATA_W)) st_d = RX_STOP;
            else bit_d = bit_q + BW'(1);
          end
        end
        RX_STOP: begin
          if (cnt_q == S_DEC) begin
            b9_d = sh_q[DATA_W];
            if (accept) begin
              byte_d = sh_q[DATA_W-1:0];
              irq_d  = 1'b1;
            end
            st_d  = RX_IDLE;
            cnt_d = '0;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0; smp_q <= 2'b11;
      byte_q <= '0; b9_q <= 1'b0; irq_q <= 1'b0; sync_q <= 2'b11;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; bit_q <= bit_d; sh_q <= sh_d; smp_q <= smp_d;
      byte_q <= byte_d; b9_q <= b9_d; irq_q <= irq_d; sync_q <= {sync_q[0], rx_i};
    end
  end

  assign byte_o = byte_q;
  assign bit9_o = b9_q;
  assign irq_o  = irq_q;

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R5
  filt_addr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (!$past(filt_i) || b9_q));
  // R6
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_q != $past(byte_q)) |-> irq_q);
endmodule

// File: rtl/nbl_tx.sv
module nbl_tx
  import nbl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              bit9_i,
  output logic              tx_o,
  output logic              done_o
);
  localparam int CW = $clog2(OVS);
  localparam int FW = DATA_W + 3;
  localparam int BW = $clog2(FW);
  localparam logic [CW-1:0] S_LAST  = CW'(OVS - 1);
  localparam logic [BW-1:0] B_FINAL = BW'(FW - 1);

  tx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [FW-1:0] sh_q, sh_d;
  logic          done_q, done_d;
  logic          sending;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q; sh_d = sh_q; done_d = 1'b0;
    unique case (st_q)
      TX_IDLE: if (start_i) begin
        st_d = TX_WAIT;
        sh_d = {1'b1, bit9_i, byte_i, 1'b0};
      end
      TX_WAIT: if (tick_i) begin
        st_d  = TX_SEND;
        cnt_d = '0;
        bit_d = '0;
      end
      TX_SEND: if (tick_i) begin
        if (cnt_q == S_LAST) begin
          cnt_d = '0;
          if (bit_q == B_FINAL) begin
            st_d   = TX_IDLE;
            done_d = 1'b1;
          end else begin
            sh_d  = {1'b1, sh_q[FW-1:1]};
            bit_d = bit_q + BW'(1);
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '1; done_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; bit_q <= bit_d; sh_q <= sh_d; done_q <= done_d;
    end
  end

  assign sending = (st_q == TX_SEND);
  assign tx_o    = sending ? sh_q[0] : 1'b1;
  assign done_o  = done_q;

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> !tx_o);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (tx_o && !sending));
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/nbl_top.sv
module nbl_top #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int TMR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic [TMR_W-1:0]  reload_i,
  input  logic              addr_filt_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tx_bit9_i,
  input  logic              tx_start_i,
  output logic              tx_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_bit9_o,
  output logic              rx_irq_o,
  output logic              tx_done_o
);
  logic [1:0] rs_q;
  logic       rst_int, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int = rs_q[1];

  nbl_baud #(.TMR_W(TMR_W)) u_baud (
    .clk(clk), .rst_n(rst_int), .reload_i(reload_i), .tick_o(tick)
  );

  nbl_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_int), .tick_i(tick), .rx_i(rx_i), .filt_i(addr_filt_i),
    .byte_o(rx_byte_o), .bit9_o(rx_bit9_o), .irq_o(rx_irq_o)
  );

  nbl_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_int), .tick_i(tick), .start_i(tx_start_i),
    .byte_i(tx_byte_i), .bit9_i(tx_bit9_i), .tx_o(tx_o), .done_o(tx_done_o)
  );
endmodule

// File: tb/nbl_top_bench.sv
`timescale 1ns/1ps
module nbl_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_i = 1'b1;
  logic [7:0] reload_i = 8'hFC;
  logic       addr_filt_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic       tx_bit9_i = 1'b0;
  logic       tx_start_i = 1'b0;
  logic       tx_o, rx_bit9_o, rx_irq_o, tx_done_o;
  logic [7:0] rx_byte_o;

  int checks = 0, errors = 0;
  int cyc = 0, irq_cnt = 0, done_cnt = 0, coin = 0, last_done = 0;
  int P = 4, BT = 64;

  nbl_top u_nbl_top (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .reload_i(reload_i),
    .addr_filt_i(addr_filt_i), .tx_byte_i(tx_byte_i), .tx_bit9_i(tx_bit9_i),
    .tx_start_i(tx_start_i), .tx_o(tx_o), .rx_byte_o(rx_byte_o),
    .rx_bit9_o(rx_bit9_o), .rx_irq_o(rx_irq_o), .tx_done_o(tx_done_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rx_irq_o) irq_cnt++;
    if (tx_done_o) begin
      done_cnt++;
      last_done = cyc;
      if (rx_irq_o) coin++;
    end
  end

  function automatic bit frame_bit(input logic [7:0] b, input bit b9, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return b[k-1];
    if (k == 9) return b9;
    return 1'b1;
  endfunction

  function automatic bit delivered(input bit filt, input bit b9, input bit stop_ok);
    return !filt || (b9 && stop_ok);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_reload(input logic [7:0] r);
    @(negedge clk);
    reload_i = r;
    P  = 256 - int'(r);
    BT = 16 * P;
    repeat (600) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b, input bit b9, input bit stop_ok);
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      rx_i = frame_bit(b, b9, k);
      repeat (BT) @(negedge clk);
    end
    if (stop_ok) begin
      rx_i = 1'b1;
      repeat (BT) @(negedge clk);
    end else begin
      rx_i = 1'b0;
      repeat (12 * P) @(negedge clk);
      rx_i = 1'b1;
      repeat (4 * P) @(negedge clk);
    end
    repeat (BT) @(negedge clk);
  endtask

  task automatic strobe_tx(input logic [7:0] b, input bit b9);
    @(negedge clk);
    tx_byte_i = b; tx_bit9_i = b9; tx_start_i = 1'b1;
    @(negedge clk);
    tx_start_i = 1'b0;
  endtask

  task automatic tx_check(input logic [7:0] b, input bit b9, input bit poke);
    int t0, guard, d0, bad;
    d0 = done_cnt;
    strobe_tx(b, b9);
    guard = 0;
    while (tx_o !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
    t0 = cyc;
    for (int k = 0; k < 11; k++) begin
      while (cyc < t0 + k * BT + BT / 2) @(negedge clk);
      chk(tx_o == frame_bit(b, b9, k), "R1", $sformatf("tx bit %0d", k),
          int'(tx_o), int'(frame_bit(b, b9, k)));
      if (poke && k == 3) begin
        tx_byte_i = ~b; tx_bit9_i = ~b9; tx_start_i = 1'b1;
        @(negedge clk);
        tx_start_i = 1'b0;
      end
    end
    while (cyc < t0 + 11 * BT + 2) @(negedge clk);
    chk(done_cnt == d0 + 1, "R2", "done pulse count", done_cnt - d0, 1);
    // R8: frame length is 11 bits of 16*(256-reload) clocks
    chk(last_done == t0 + 11 * BT, "R8", "done cycle offset", last_done - t0, 11 * BT);
    bad = 0;
    repeat (2 * BT) begin @(negedge clk); if (tx_o !== 1'b1) bad++; end
    chk(bad == 0 && done_cnt == d0 + 1, "R2", "line idle after frame", bad, 0);
  endtask

  task automatic rx_case(input logic [7:0] b, input bit b9, input bit filt,
                         input bit stop_ok, input string req, inout logic [7:0] exp_b);
    int i0;
    bit acc;
    @(negedge clk);
    addr_filt_i = filt;
    i0 = irq_cnt;
    acc = delivered(filt, b9, stop_ok);
    send_rx(b, b9, stop_ok);
    if (acc) exp_b = b;
    chk(irq_cnt == i0 + (acc ? 1 : 0), req, "irq count", irq_cnt - i0, acc ? 1 : 0);
    chk(rx_byte_o == exp_b, req, "rx byte", int'(rx_byte_o), int'(exp_b));
    chk(rx_bit9_o == b9, "R9", "ninth bit status", int'(rx_bit9_o), int'(b9));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] eb;
    int i0, d0;
    eb = 8'h00;
    void'($urandom(32'd20250611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_o == 1'b1, "R1", "reset line idle", int'(tx_o), 1);
    chk(rx_irq_o == 1'b0 && tx_done_o == 1'b0, "R2", "reset pulses low",
        int'({rx_irq_o, tx_done_o}), 0);
    chk(rx_byte_o == 8'h00 && rx_bit9_o == 1'b0, "R3", "reset rx state",
        int'({rx_bit9_o, rx_byte_o}), 0);

    set_reload(8'hFC);
    tx_check(8'hA5, 1'b1, 1'b0);
    tx_check(8'h3C, 1'b0, 1'b1);   // R2: strobe during frame ignored
    set_reload(8'hF8);
    tx_check(8'h81, 1'b0, 1'b0);   // R8: second divide
    set_reload(8'hFC);

    rx_case(8'hA5, 1'b1, 1'b1, 1'b1, "R4", eb);
    rx_case(8'h3C, 1'b0, 1'b1, 1'b1, "R5", eb);
    rx_case(8'h3C, 1'b0, 1'b0, 1'b1, "R3", eb);
    rx_case(8'hD2, 1'b1, 1'b0, 1'b1, "R3", eb);
    rx_case(8'h77, 1'b1, 1'b1, 1'b0, "R6", eb);

    // R7: short low pulse rejected
    i0 = irq_cnt;
    @(negedge clk);
    addr_filt_i = 1'b0;
    rx_i = 1'b0;
    repeat (4 * P) @(negedge clk);
    rx_i = 1'b1;
    repeat (2 * BT) @(negedge clk);
    chk(irq_cnt == i0, "R7", "false start irq", irq_cnt - i0, 0);
    chk(rx_byte_o == eb, "R7", "false start byte", int'(rx_byte_o), int'(eb));

    for (int n = 0; n < 30; n++) begin
      logic [7:0] rb;
      bit rb9, rf;
      rb  = 8'($urandom);
      rb9 = 1'($urandom);
      rf  = 1'($urandom);
      rx_case(rb, rb9, rf, 1'b1, rf ? (rb9 ? "R4" : "R5") : "R3", eb);
    end

    // R3 and R2 together: receive decision may share a cycle with tx done
    @(negedge clk);
    addr_filt_i = 1'b0;
    for (int d = 0; d <= 16; d++) begin
      logic [7:0] sb;
      sb = 8'(d * 13 + 7);
      i0 = irq_cnt; d0 = done_cnt;
      fork
        strobe_tx(~sb, 1'b0);
        begin repeat (d * P) @(negedge clk); send_rx(sb, 1'b1, 1'b1); end
      join
      repeat (BT) @(negedge clk);
      chk(irq_cnt == i0 + 1, "R3", "overlap irq count", irq_cnt - i0, 1);
      chk(done_cnt == d0 + 1, "R2", "overlap done count", done_cnt - d0, 1);
      chk(rx_byte_o == sb, "R3", "overlap rx byte", int'(rx_byte_o), int'(sb));
    end
    $display("overlap offsets with coincident pulses: %0d", coin);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule